// File: doc/BRIEF.md
# Decode Operand Bypass Selector

This block picks the two source operands that an instruction leaves the decode stage with in a five-stage in-order pipeline. Each operand either comes from the register-file read port or is taken from one of five results that older instructions have produced but not yet written back. Those five results are:

- the ALU result being computed in execute this cycle;
- the memory-stage read data;
- the memory-stage ALU value;
- the write-back read data;
- the write-back ALU value.

A result is used when its destination register ID equals the operand's source register ID. When more than one result matches the same register, the youngest producer wins, so the operand matches what a strictly serial machine would have read. Register ID 15 means "no register". A source ID of 15 always takes the register-file value. A destination ID of 15 never matches.

The block is purely combinational and sits between the register-file read ports and the decode/execute pipeline register. Hazards that bypassing cannot cover, such as a load followed at once by its consumer, are detected elsewhere.

Top module: `fwd_operand_unit`

## Requirements
- R1: When no bypass source's destination ID equals the operand's source ID, the operand equals the register-file read value for that port.
- R2: An execute-stage ALU result whose destination ID matches is forwarded in the same cycle it is computed.
- R3: The fixed priority, highest first, is: execute ALU result, memory read data, memory ALU value, write-back read data, write-back ALU value, register file. The highest-priority matching source supplies the operand.
- R4: A matching memory-stage read value is forwarded when no execute-stage match exists.
- R5: A matching memory-stage ALU value is forwarded when neither execute nor memory read data match.
- R6: A matching write-back read or ALU value is forwarded instead of the register-file value, even though the register file does not yet hold it.
- R7: A source ID of 15 (4'hF) selects the register-file value, even when every destination ID is also 15.
- R8: A destination ID of 15 never produces a match, whatever its value.
- R9: Operand A and operand B are selected independently. Each uses only its own source ID and its own register-file read value, so equal inputs on both ports give equal outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_i | input | REG_W | Source register ID for operand A |
| src_b_i | input | REG_W | Source register ID for operand B |
| rf_a_i | input | DATA_W | Register-file read value for operand A |
| rf_b_i | input | DATA_W | Register-file read value for operand B |
| ex_alu_val_i | input | DATA_W | ALU result computed in execute this cycle |
| ex_alu_dst_i | input | REG_W | Destination ID of the execute ALU result |
| mem_alu_val_i | input | DATA_W | ALU value held in the memory stage |
| mem_alu_dst_i | input | REG_W | Destination ID of the memory ALU value |
| mem_rd_val_i | input | DATA_W | Data read by the memory stage |
| mem_rd_dst_i | input | REG_W | Destination ID of the memory read data |
| wb_alu_val_i | input | DATA_W | ALU value held in write-back |
| wb_alu_dst_i | input | REG_W | Destination ID of the write-back ALU value |
| wb_rd_val_i | input | DATA_W | Read data held in write-back |
| wb_rd_dst_i | input | REG_W | Destination ID of the write-back read data |
| op_a_o | output | DATA_W | Selected operand A |
| op_b_o | output | DATA_W | Selected operand B |

## Verification
The bench builds the block with its default parameters: 32-bit data and 4-bit register IDs, so the no-register code is 4'hF. With those widths, the random phase draws every ID from the set {0, 1, 2, 3, 15}. Several stages therefore often name the same register, and 15 shows up often as both a source and a destination. This makes multi-way priority collisions and the no-register corner cases frequent, not rare. Directed vectors first walk each rung of the priority ladder on its own.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int unsigned N_SRC = 5;

  // index order is priority order: lower index = younger producer
  typedef enum int unsigned {
    SRC_EX_ALU  = 0,
    SRC_MEM_RD  = 1,
    SRC_MEM_ALU = 2,
    SRC_WB_RD   = 3,
    SRC_WB_ALU  = 4
  } fwd_src_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int unsigned REG_W = 4
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] dst_i,
  output logic             hit_o
);
  localparam logic [REG_W-1:0] NO_REG = {REG_W{1'b1}};

  // src == dst and dst != NO_REG imply src != NO_REG
  assign hit_o = (dst_i != NO_REG) && (dst_i == src_i);
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_W  = 4,
  parameter int unsigned N_SRC  = 5
) (
  input  logic [REG_W-1:0]              src_i,
  input  logic [DATA_W-1:0]             rf_i,
  input  logic [N_SRC-1:0][DATA_W-1:0]  cand_val_i,
  input  logic [N_SRC-1:0][REG_W-1:0]   cand_dst_i,
  output logic [DATA_W-1:0]             val_o
);
  localparam logic [REG_W-1:0] NO_REG = {REG_W{1'b1}};

  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_match
    fwd_match #(.REG_W(REG_W)) u_match (
      .src_i (src_i),
      .dst_i (cand_dst_i[g]),
      .hit_o (hit[g])
    );
  end

  // lowest index overrides: walk from oldest to youngest
  always_comb begin
    val_o = rf_i;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (hit[i]) val_o = cand_val_i[i];
    end
  end

  always_comb begin
    if (hit == '0) begin
      a_r1_rf_when_no_hit: assert (val_o == rf_i)
        else $error("selector: no hit but operand not from register file");
    end
    if (hit[0]) begin
      a_r2_ex_alu_first: assert (val_o == cand_val_i[0])
        else $error("selector: execute match not forwarded");
    end
    if (src_i == NO_REG) begin
      a_r7_no_reg_src_no_hit: assert (hit == '0)
        else $error("selector: no-register source matched");
    end
    for (int i = 0; i < N_SRC; i++) begin
      if (cand_dst_i[i] == NO_REG) begin
        a_r8_no_reg_dst_no_hit: assert (!hit[i])
          else $error("selector: no-register destination matched");
      end
    end
  end
endmodule

// File: rtl/fwd_operand_unit.sv
module fwd_operand_unit
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_W  = 4
) (
  input  logic [REG_W-1:0]  src_a_i,
  input  logic [REG_W-1:0]  src_b_i,
  input  logic [DATA_W-1:0] rf_a_i,
  input  logic [DATA_W-1:0] rf_b_i,
  input  logic [DATA_W-1:0] ex_alu_val_i,
  input  logic [REG_W-1:0]  ex_alu_dst_i,
  input  logic [DATA_W-1:0] mem_alu_val_i,
  input  logic [REG_W-1:0]  mem_alu_dst_i,
  input  logic [DATA_W-1:0] mem_rd_val_i,
  input  logic [REG_W-1:0]  mem_rd_dst_i,
  input  logic [DATA_W-1:0] wb_alu_val_i,
  input  logic [REG_W-1:0]  wb_alu_dst_i,
  input  logic [DATA_W-1:0] wb_rd_val_i,
  input  logic [REG_W-1:0]  wb_rd_dst_i,
  output logic [DATA_W-1:0] op_a_o,
  output logic [DATA_W-1:0] op_b_o
);
  localparam int unsigned N_PORT = 2;
  localparam logic [REG_W-1:0] NO_REG = {REG_W{1'b1}};

  logic [N_SRC-1:0][DATA_W-1:0] cand_val;
  logic [N_SRC-1:0][REG_W-1:0]  cand_dst;
  logic [N_PORT-1:0][REG_W-1:0]  src;
  logic [N_PORT-1:0][DATA_W-1:0] rf;
  logic [N_PORT-1:0][DATA_W-1:0] op;

  always_comb begin
    cand_val[SRC_EX_ALU]  = ex_alu_val_i;   cand_dst[SRC_EX_ALU]  = ex_alu_dst_i;
    cand_val[SRC_MEM_RD]  = mem_rd_val_i;   cand_dst[SRC_MEM_RD]  = mem_rd_dst_i;
    cand_val[SRC_MEM_ALU] = mem_alu_val_i;  cand_dst[SRC_MEM_ALU] = mem_alu_dst_i;
    cand_val[SRC_WB_RD]   = wb_rd_val_i;    cand_dst[SRC_WB_RD]   = wb_rd_dst_i;
    cand_val[SRC_WB_ALU]  = wb_alu_val_i;   cand_dst[SRC_WB_ALU]  = wb_alu_dst_i;
  end

  assign src = {src_b_i, src_a_i};
  assign rf  = {rf_b_i, rf_a_i};

  for (genvar p = 0; p < N_PORT; p++) begin : g_port
    fwd_operand_sel #(
      .DATA_W (DATA_W),
      .REG_W  (REG_W),
      .N_SRC  (N_SRC)
    ) u_sel (
      .src_i      (src[p]),
      .rf_i       (rf[p]),
      .cand_val_i (cand_val),
      .cand_dst_i (cand_dst),
      .val_o      (op[p])
    );
  end

  assign op_a_o = op[0];
  assign op_b_o = op[1];

  always_comb begin
    if (src_a_i == src_b_i && rf_a_i == rf_b_i) begin
      a_r9_ports_agree: assert (op_a_o == op_b_o)
        else $error("unit: identical port inputs gave different operands");
    end
    if (src_a_i == NO_REG) begin
      a_r7_port_a_rf: assert (op_a_o == rf_a_i)
        else $error("unit: no-register source A not from register file");
    end
  end
endmodule

// File: tb/fwd_operand_unit_tb_top.sv
module fwd_operand_unit_tb_top;
  localparam int DW = 32;
  localparam int RW = 4;
  localparam logic [RW-1:0] NOREG = 4'hF;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [RW-1:0] src_a, src_b, ex_d, ma_d, mr_d, wa_d, wr_d;
  logic [DW-1:0] rf_a, rf_b, ex_v, ma_v, mr_v, wa_v, wr_v;
  logic [DW-1:0] op_a, op_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  fwd_operand_unit #(.DATA_W(DW), .REG_W(RW)) dut_i (
    .src_a_i(src_a), .src_b_i(src_b), .rf_a_i(rf_a), .rf_b_i(rf_b),
    .ex_alu_val_i(ex_v), .ex_alu_dst_i(ex_d),
    .mem_alu_val_i(ma_v), .mem_alu_dst_i(ma_d),
    .mem_rd_val_i(mr_v), .mem_rd_dst_i(mr_d),
    .wb_alu_val_i(wa_v), .wb_alu_dst_i(wa_d),
    .wb_rd_val_i(wr_v), .wb_rd_dst_i(wr_d),
    .op_a_o(op_a), .op_b_o(op_b)
  );

  // behavioural model: walk producers youngest first, serial semantics
  function automatic logic [DW-1:0] model(input logic [RW-1:0] s,
                                          input logic [DW-1:0] r,
                                          output string why);
    logic [RW-1:0] d_q[$];
    logic [DW-1:0] v_q[$];
    string         n_q[$];
    d_q = '{ex_d, mr_d, ma_d, wr_d, wa_d};
    v_q = '{ex_v, mr_v, ma_v, wr_v, wa_v};
    n_q = '{"R2/R3", "R4/R3", "R5/R3", "R6/R3", "R6/R3"};
    if (s == NOREG) begin
      why = "R7";
      return r;
    end
    foreach (d_q[k]) begin
      if (d_q[k] == s) begin
        why = n_q[k];
        return v_q[k];
      end
    end
    why = "R1/R8";
    return r;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic compare();
    string wa, wb;
    logic [DW-1:0] ea, eb;
    ea = model(src_a, rf_a, wa);
    eb = model(src_b, rf_b, wb);
    check({wa, " port A"}, op_a, ea);
    check({wb, " port B (R9)"}, op_b, eb);
  endtask

  task automatic idle();
    src_a = 4'd1; src_b = 4'd2;
    rf_a = 32'hAAAA_0001; rf_b = 32'hBBBB_0002;
    ex_d = NOREG; ma_d = NOREG; mr_d = NOREG; wa_d = NOREG; wr_d = NOREG;
    ex_v = 32'hE0E0_0000; mr_v = 32'hD0D0_0000; ma_v = 32'hC0C0_0000;
    wr_v = 32'hB0B0_0000; wa_v = 32'hA0A0_0000;
  endtask

  function automatic logic [RW-1:0] pick_id();
    int x;
    x = $urandom_range(0, 4);
    return (x == 4) ? NOREG : RW'(x);
  endfunction

  initial begin
    #(10 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    @(negedge clk);
    // idle state: nothing in flight -> register file
    check("R1 idle A", op_a, 32'hAAAA_0001);
    check("R1 idle B", op_b, 32'hBBBB_0002);

    // priority ladder on port A, register 1; enable oldest to youngest
    @(posedge clk); wa_d = 4'd1;
    @(negedge clk); check("R6 wb alu", op_a, 32'hA0A0_0000);
    @(posedge clk); wr_d = 4'd1;
    @(negedge clk); check("R6/R3 wb rd over wb alu", op_a, 32'hB0B0_0000);
    @(posedge clk); ma_d = 4'd1;
    @(negedge clk); check("R5/R3 mem alu over wb", op_a, 32'hC0C0_0000);
    @(posedge clk); mr_d = 4'd1;
    @(negedge clk); check("R4/R3 mem rd over mem alu", op_a, 32'hD0D0_0000);
    @(posedge clk); ex_d = 4'd1;
    @(negedge clk); check("R2/R3 ex alu over all", op_a, 32'hE0E0_0000);
    check("R9 port B untouched", op_b, 32'hBBBB_0002);

    // port B hit while port A misses
    @(posedge clk); idle(); ma_d = 4'd2;
    @(negedge clk);
    check("R5 port B mem alu", op_b, 32'hC0C0_0000);
    check("R9 port A rf", op_a, 32'hAAAA_0001);

    // no-register source with all destinations 15
    @(posedge clk); idle(); src_a = NOREG; src_b = NOREG;
    @(negedge clk);
    check("R7 src 15 A", op_a, 32'hAAAA_0001);
    check("R7 src 15 B", op_b, 32'hBBBB_0002);

    // destination 15 never matches a real register
    @(posedge clk); idle(); src_a = 4'd3; wa_d = 4'd4; ex_d = NOREG;
    @(negedge clk); check("R8/R1 mismatched dst", op_a, 32'hAAAA_0001);

    // randomised collisions, compared every clock
    for (int n = 0; n < 2000; n++) begin
      @(posedge clk);
      src_a = pick_id(); src_b = pick_id();
      ex_d = pick_id(); mr_d = pick_id(); ma_d = pick_id();
      wr_d = pick_id(); wa_d = pick_id();
      rf_a = $urandom(); rf_b = (n % 7 == 0) ? rf_a : $urandom();
      if (n % 7 == 0) src_b = src_a;
      ex_v = $urandom(); mr_v = $urandom(); ma_v = $urandom();
      wr_v = $urandom(); wa_v = $urandom();
      @(negedge clk);
      compare();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule